// File: doc/BRIEF.md
# DVMA Translation Unit Configuration Register Bank

This block holds the software-visible configuration and error state of a DVMA address translation unit. A host reaches it through a simple word-wide request interface: one request per cycle, a write committing at the clock edge and read data returned combinationally in the same cycle. Each named register applies its own write mask and hard-wired one bits, and has its own reset value. The control register's range code is decoded into the start address of the translation window. That start address and the page-table base are driven out continuously to the translator.

The translator reports a failed lookup through a capture strobe carrying a status word and the faulting address. The bank latches both and raises a level interrupt. Software lowers the interrupt by reading or writing either fault register. The mask identification register only ever gains bits. Word offsets that decode to no named register fall into a small scratch store, so those locations read back what was last written to them.

Top module: `dvma_cfg_regs`

## Requirements
- R1: Reset values: control = {IMPL_VER, 24'h0}, arbitration enable = 0x00000008, fault status = 0x00800000, arbiter enable = 0x00000003, mask ID = 0x23000000, all other registers and scratch = 0, win_start = 0, irq = 0.
- R2: A write to control (byte offset 0x0000) keeps bit 0 (enable) and bits 4:2 (range code) only (mask 0x0000001D); bits 31:24 always read as IMPL_VER.
- R3: After a control write with range code c in bits 4:2, win_start equals 0xFFFFFFFF shifted left by 24+c (c=0 gives 0xFF000000, c=7 gives 0x80000000); win_start changes on no other access.
- R4: Table base (0x0004) keeps mask 0x07FFFC00 and is driven on tbl_base; the TLB flush (0x0014) and page flush (0x0018) registers keep the full word.
- R5: Fault status (0x1000) keeps mask 0xFF0FFFFF on a write and always reads with bit 23 set; fault address (0x1004) keeps the full word.
- R6: Any read or write of fault status or fault address lowers irq at the next clock edge.
- R7: A flt_cap cycle loads fault status with (flt_status & 0xFF0FFFFF) | 0x00800000 and fault address with flt_addr and raises irq at the next edge, winning over a bus write to or a read of either fault register in the same cycle.
- R8: Arbiter enable (0x1008) keeps mask 0x801F000F with bit 0 forced to 1; the four slot configuration registers (0x1010, 0x1014, 0x1018, 0x101C) keep mask 0x00010003.
- R9: Arbitration enable (0x2000) keeps mask 0x001F0000 with bit 3 forced to 1.
- R10: A write to mask ID (0x3018) ORs (wdata & 0x00FFFFFF) into its value; no bit ever clears.
- R11: Any other word offset is full-width scratch storage selected by word index modulo SCRATCH_WORDS (offsets 0x0008 and 0x0048 alias under the default of 16).
- R12: Byte address bits 1:0 are ignored; read data appears in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one word per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq | output | 1 | Level fault interrupt |
| win_start | output | 32 | Decoded translation window start |
| tbl_base | output | 32 | Page-table base register |
| flt_cap | input | 1 | Fault capture strobe from the translator |
| flt_status | input | 32 | Status word to capture |
| flt_addr | input | 32 | Faulting address to capture |

## Verification
The hardest case to reach is a capture that coincides with a bus access to a fault register. In that cycle the capture must win over both the stored value and the interrupt clear. The bench drives flt_cap in the same cycle as a fault-status write, and again in the same cycle as a fault-address read. It then checks that the captured values survive and that irq stays high. All eight range codes, every masked register under all-ones, all-zeros and alternating patterns, and the scratch aliasing are swept, with each expected value computed arithmetically.

// File: rtl/dvma_cfg_pkg.sv
// Shared constants and the register selector type of the DVMA config bank.
// Assumes word indices fit in 12 bits (a 16 KB space).
package dvma_cfg_pkg;

    typedef enum logic [3:0] {
        SEL_CTRL, SEL_BASE, SEL_TFL, SEL_PFL, SEL_FSR, SEL_FAR,
        SEL_ARB, SEL_SLOT, SEL_ARBEN, SEL_MID, SEL_SCR
    } reg_sel_e;

    // word indices (byte offset >> 2)
    localparam logic [11:0] IDX_CTRL  = 12'h000;
    localparam logic [11:0] IDX_BASE  = 12'h001;
    localparam logic [11:0] IDX_TFL   = 12'h005;
    localparam logic [11:0] IDX_PFL   = 12'h006;
    localparam logic [11:0] IDX_FSR   = 12'h400;
    localparam logic [11:0] IDX_FAR   = 12'h401;
    localparam logic [11:0] IDX_ARB   = 12'h402;
    localparam logic [11:0] IDX_SLOT0 = 12'h404;
    localparam logic [11:0] IDX_SLOT1 = 12'h405;
    localparam logic [11:0] IDX_SLOT2 = 12'h406;
    localparam logic [11:0] IDX_SLOT3 = 12'h407;
    localparam logic [11:0] IDX_ARBEN = 12'h800;
    localparam logic [11:0] IDX_MID   = 12'hC06;

    // write masks and forced-one bits
    localparam logic [31:0] CTRL_MASK  = 32'h0000_001D;
    localparam logic [31:0] BASE_MASK  = 32'h07FF_FC00;
    localparam logic [31:0] FSR_MASK   = 32'hFF0F_FFFF;
    localparam logic [31:0] FSR_FORCE  = 32'h0080_0000;
    localparam logic [31:0] ARB_MASK   = 32'h801F_000F;
    localparam logic [31:0] ARB_FORCE  = 32'h0000_0001;
    localparam logic [31:0] SLOT_MASK  = 32'h0001_0003;
    localparam logic [31:0] ARBEN_MASK = 32'h001F_0000;
    localparam logic [31:0] ARBEN_FORCE = 32'h0000_0008;
    localparam logic [31:0] MID_MASK   = 32'h00FF_FFFF;

    // reset values
    localparam logic [31:0] ARB_RST   = 32'h0000_0003;
    localparam logic [31:0] MID_RST   = 32'h2300_0000;

endpackage

// File: rtl/dvma_win_decode.sv
// Translation window decoder: converts the 3-bit range code into the
// window start address and holds it until the next control write.
// Assumes load is a single-cycle strobe qualified by the caller.
module dvma_win_decode (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [2:0]  code,
    output logic [31:0] start_q
);
    localparam logic [31:0] MIN_WIN = 32'h0100_0000;   // 16 MB

    // latch the window start on a control write
    always_ff @(posedge clk) begin
        if (!rst_n)    start_q <= '0;
        else if (load) start_q <= ~((MIN_WIN << code) - 32'd1);
    end

    // R3
    win_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($countones(start_q) == 32'(8 - {29'd0, $past(code)})));

endmodule

// File: rtl/dvma_fault_regs.sv
// Fault status / fault address pair and the level interrupt.
// Capture from the translator outranks any bus access in the same cycle.
module dvma_fault_regs
    import dvma_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc,        // read or write of either fault register
    input  logic        wr_fsr,
    input  logic        wr_far,
    input  logic [31:0] wdata,
    input  logic        cap,
    input  logic [31:0] cap_status,
    input  logic [31:0] cap_addr,
    output logic [31:0] fsr_q,
    output logic [31:0] far_q,
    output logic        irq_q
);
    // capture, bus update and interrupt handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_q <= FSR_FORCE;
            far_q <= '0;
            irq_q <= 1'b0;
        end else if (cap) begin
            fsr_q <= (cap_status & FSR_MASK) | FSR_FORCE;
            far_q <= cap_addr;
            irq_q <= 1'b1;
        end else begin
            if (wr_fsr) fsr_q <= (wdata & FSR_MASK) | FSR_FORCE;
            if (wr_far) far_q <= wdata;
            if (acc)    irq_q <= 1'b0;
        end
    end

    // R7
    cap_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> irq_q && far_q == $past(cap_addr));
    // R6
    acc_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cap) |=> !irq_q);
    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(cap));

endmodule

// File: rtl/dvma_scratch_ram.sv
// Generic word storage for offsets with no named register.
// Assumes WORDS is a power of two; index is the low bits of the word index.
module dvma_scratch_ram #(
    parameter int WORDS = 16,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem_q [WORDS];

    // clear on reset, store on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    // asynchronous read port
    assign rdata = mem_q[idx];

endmodule

// File: rtl/dvma_cfg_regs.sv
// Configuration register bank of a DVMA translation unit.
// One word access per cycle; writes commit at the edge, reads are
// combinational. Exports window start and table base to the translator.
module dvma_cfg_regs
    import dvma_cfg_pkg::*;
#(
    parameter int          ADDR_W        = 14,
    parameter logic [7:0]  IMPL_VER      = 8'h41,
    parameter int          SCRATCH_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [31:0]       win_start,
    output logic [31:0]       tbl_base,
    input  logic              flt_cap,
    input  logic [31:0]       flt_status,
    input  logic [31:0]       flt_addr
);
    localparam int          WIDX_W   = ADDR_W - 2;
    localparam int          SCR_W    = $clog2(SCRATCH_WORDS);
    localparam logic [31:0] CTRL_RST = {IMPL_VER, 24'h0};

    logic [WIDX_W-1:0] widx;
    logic              unused_lsb;
    reg_sel_e          sel;
    logic              wr;
    logic [31:0] ctrl_q, base_q, tfl_q, pfl_q, arb_q, arben_q, mid_q;
    logic [31:0] slot_q [4];
    logic [31:0] fsr_q, far_q, scr_rdata;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];
    assign wr         = bus_req && bus_we;

    // decode the word index into a register selector
    always_comb begin
        case (widx)
            WIDX_W'(IDX_CTRL):  sel = SEL_CTRL;
            WIDX_W'(IDX_BASE):  sel = SEL_BASE;
            WIDX_W'(IDX_TFL):   sel = SEL_TFL;
            WIDX_W'(IDX_PFL):   sel = SEL_PFL;
            WIDX_W'(IDX_FSR):   sel = SEL_FSR;
            WIDX_W'(IDX_FAR):   sel = SEL_FAR;
            WIDX_W'(IDX_ARB):   sel = SEL_ARB;
            WIDX_W'(IDX_SLOT0), WIDX_W'(IDX_SLOT1),
            WIDX_W'(IDX_SLOT2), WIDX_W'(IDX_SLOT3): sel = SEL_SLOT;
            WIDX_W'(IDX_ARBEN): sel = SEL_ARBEN;
            WIDX_W'(IDX_MID):   sel = SEL_MID;
            default:            sel = SEL_SCR;
        endcase
    end

    // masked register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            base_q  <= '0;
            tfl_q   <= '0;
            pfl_q   <= '0;
            arb_q   <= ARB_RST;
            arben_q <= ARBEN_FORCE;
            mid_q   <= MID_RST;
            for (int i = 0; i < 4; i++) slot_q[i] <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CTRL:  ctrl_q  <= (bus_wdata & CTRL_MASK) | CTRL_RST;
                SEL_BASE:  base_q  <= bus_wdata & BASE_MASK;
                SEL_TFL:   tfl_q   <= bus_wdata;
                SEL_PFL:   pfl_q   <= bus_wdata;
                SEL_ARB:   arb_q   <= (bus_wdata & ARB_MASK) | ARB_FORCE;
                SEL_SLOT:  slot_q[widx[1:0]] <= bus_wdata & SLOT_MASK;
                SEL_ARBEN: arben_q <= (bus_wdata & ARBEN_MASK) | ARBEN_FORCE;
                SEL_MID:   mid_q   <= mid_q | (bus_wdata & MID_MASK);
                default:   ;
            endcase
        end
    end

    dvma_win_decode win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr && sel == SEL_CTRL),
        .code    (bus_wdata[4:2]),
        .start_q (win_start)
    );

    dvma_fault_regs flt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (bus_req && (sel == SEL_FSR || sel == SEL_FAR)),
        .wr_fsr     (wr && sel == SEL_FSR),
        .wr_far     (wr && sel == SEL_FAR),
        .wdata      (bus_wdata),
        .cap        (flt_cap),
        .cap_status (flt_status),
        .cap_addr   (flt_addr),
        .fsr_q      (fsr_q),
        .far_q      (far_q),
        .irq_q      (irq)
    );

    dvma_scratch_ram #(.WORDS(SCRATCH_WORDS)) scr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr && sel == SEL_SCR),
        .idx   (widx[SCR_W-1:0]),
        .wdata (bus_wdata),
        .rdata (scr_rdata)
    );

    // read data multiplexer
    always_comb begin
        case (sel)
            SEL_CTRL:  bus_rdata = ctrl_q;
            SEL_BASE:  bus_rdata = base_q;
            SEL_TFL:   bus_rdata = tfl_q;
            SEL_PFL:   bus_rdata = pfl_q;
            SEL_FSR:   bus_rdata = fsr_q;
            SEL_FAR:   bus_rdata = far_q;
            SEL_ARB:   bus_rdata = arb_q;
            SEL_SLOT:  bus_rdata = slot_q[widx[1:0]];
            SEL_ARBEN: bus_rdata = arben_q;
            SEL_MID:   bus_rdata = mid_q;
            default:   bus_rdata = scr_rdata;
        endcase
    end

    assign tbl_base = base_q;

    // R5
    fsr_bit23_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && sel == SEL_FSR) |-> bus_rdata[23]);
    // R8
    arb_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && sel == SEL_ARB) |-> bus_rdata[0]);
    // R9
    arben_bit3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && sel == SEL_ARBEN) |-> bus_rdata[3]);
    // R2
    ctrl_ver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && sel == SEL_CTRL) |-> bus_rdata[31:24] == IMPL_VER);
    // R10
    mid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mid_q & $past(mid_q)) == $past(mid_q)));
    // R3
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_CTRL) |=> $stable(win_start));

endmodule

// File: tb/dvma_cfg_regs_tb.sv
// Self-checking bench: sweeps range codes, register masks and scratch
// aliasing, and forces capture/bus collisions on the fault registers.
module dvma_cfg_regs_tb_top;
    localparam logic [7:0] VER = 8'h41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, win_start, tbl_base;
    logic        irq;
    logic        flt_cap = 1'b0;
    logic [31:0] flt_status = '0, flt_addr = '0;

    int checks = 0, errors = 0, cyc = 0;
    logic [31:0] rd_v;

    always #4 clk = ~clk;

    dvma_cfg_regs #(.ADDR_W(14), .IMPL_VER(VER), .SCRATCH_WORDS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .win_start(win_start), .tbl_base(tbl_base),
        .flt_cap(flt_cap), .flt_status(flt_status), .flt_addr(flt_addr));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1 rd_v = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string req);
        acc(1'b0, a, '0);
        check(req, rd_v, exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual %0d expected <100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [13:0] t_addr [9] = '{14'h0004, 14'h0014, 14'h0018, 14'h1008,
                                14'h1010, 14'h1014, 14'h1018, 14'h101C, 14'h2000};
    logic [31:0] t_mask [9] = '{32'h07FFFC00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h801F000F,
                                32'h00010003, 32'h00010003, 32'h00010003, 32'h00010003,
                                32'h001F0000};
    logic [31:0] t_frc  [9] = '{32'h0, 32'h0, 32'h0, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8};
    logic [31:0] pats   [3] = '{32'hFFFFFFFF, 32'h00000000, 32'hA5A5A5A5};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 win_start", win_start, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        rd(14'h0000, {VER, 24'h0}, "R1 ctrl");
        rd(14'h2000, 32'h00000008, "R1 arben");
        rd(14'h1000, 32'h00800000, "R1 fsr");
        rd(14'h1008, 32'h00000003, "R1 arb");
        rd(14'h3018, 32'h23000000, "R1 mid");
        rd(14'h1004, 32'h0, "R1 far");
        for (int i = 0; i < 9; i++) rd(t_addr[i], 32'h0 | (i == 3 ? 32'h3 : t_frc[i]), "R1 others");
        rd(14'h0008, 32'h0, "R1 scratch");

        // R2 / R3 range sweep
        for (int c = 0; c < 8; c++) begin
            acc(1'b1, 14'h0000, 32'h00000001 | (32'(c) << 2));
            check("R3 win_start", win_start, 32'hFFFFFFFF << (24 + c));
            rd(14'h0000, {VER, 24'h0} | 32'h1 | (32'(c) << 2), "R2 ctrl");
            acc(1'b1, 14'h0004, 32'h0);
            check("R3 hold", win_start, 32'hFFFFFFFF << (24 + c));
        end
        acc(1'b1, 14'h0000, 32'hFFFFFFFF);
        rd(14'h0000, {VER, 24'h0} | 32'h1D, "R2 ctrl ones");
        check("R3 ones", win_start, 32'h80000000);

        // R4 R8 R9 mask sweep
        for (int i = 0; i < 9; i++)
            for (int p = 0; p < 3; p++) begin
                acc(1'b1, t_addr[i], pats[p]);
                rd(t_addr[i], (pats[p] & t_mask[i]) | t_frc[i],
                   i < 3 ? "R4 mask" : (i == 8 ? "R9 mask" : "R8 mask"));
            end
        acc(1'b1, 14'h0004, 32'h12345678);
        check("R4 tbl_base", tbl_base, 32'h12345678 & 32'h07FFFC00);

        // R5 fault register masks
        for (int p = 0; p < 3; p++) begin
            acc(1'b1, 14'h1000, pats[p]);
            rd(14'h1000, (pats[p] & 32'hFF0FFFFF) | 32'h00800000, "R5 fsr");
            acc(1'b1, 14'h1004, pats[p]);
            rd(14'h1004, pats[p], "R5 far");
        end

        // R7 capture, then R6 clear by read of each fault register
        @(negedge clk); flt_cap = 1'b1; flt_status = 32'h40700001; flt_addr = 32'hDEAD0000;
        @(negedge clk); flt_cap = 1'b0;
        check("R7 irq set", {31'd0, irq}, 32'h1);
        rd(14'h1000, 32'h40800001, "R7 fsr captured");
        check("R6 irq cleared by fsr read", {31'd0, irq}, 32'h0);
        @(negedge clk); flt_cap = 1'b1;
        @(negedge clk); flt_cap = 1'b0;
        rd(14'h1004, 32'hDEAD0000, "R7 far captured");
        check("R6 irq cleared by far read", {31'd0, irq}, 32'h0);
        @(negedge clk); flt_cap = 1'b1;
        @(negedge clk); flt_cap = 1'b0;
        acc(1'b1, 14'h1004, 32'h5);
        check("R6 irq cleared by far write", {31'd0, irq}, 32'h0);

        // R7 capture collides with fsr write
        @(negedge clk);
        flt_cap = 1'b1; flt_status = 32'h0000ABCD; flt_addr = 32'h00C0FFEE;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 14'h1000; bus_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        flt_cap = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        check("R7 irq priority", {31'd0, irq}, 32'h1);
        // R7 capture collides with far read
        @(negedge clk);
        flt_cap = 1'b1; flt_addr = 32'h0BADF00D;
        bus_req = 1'b1; bus_addr = 14'h1004;
        @(negedge clk);
        flt_cap = 1'b0; bus_req = 1'b0;
        check("R7 irq over read", {31'd0, irq}, 32'h1);
        rd(14'h1004, 32'h0BADF00D, "R7 far over read");
        rd(14'h1000, 32'h0080ABCD, "R7 fsr over write");

        // R10 mask ID accumulation
        acc(1'b1, 14'h3018, 32'h00000011);
        rd(14'h3018, 32'h23000011, "R10 or1");
        acc(1'b1, 14'h3018, 32'hFF000100);
        rd(14'h3018, 32'h23000111, "R10 or2");
        acc(1'b1, 14'h3018, 32'h0);
        rd(14'h3018, 32'h23000111, "R10 no clear");

        // R11 scratch storage and aliasing
        for (int i = 2; i < 16; i++) begin
            if (i == 5 || i == 6) continue;
            acc(1'b1, 14'(4 * i), (32'(i) * 32'h01010101) ^ 32'hC3);
        end
        for (int i = 2; i < 16; i++) begin
            if (i == 5 || i == 6) continue;
            rd(14'(4 * i), (32'(i) * 32'h01010101) ^ 32'hC3, "R11 readback");
            rd(14'(64 + 4 * i), (32'(i) * 32'h01010101) ^ 32'hC3, "R11 alias");
        end
        acc(1'b1, 14'h2004, 32'h77665544);
        rd(14'h0044, 32'h77665544, "R11 high alias");

        // R12 low address bits ignored
        acc(1'b1, 14'h1009, 32'h80000002);
        rd(14'h100B, 32'h80000003, "R12 low bits");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule